// File: doc/BRIEF.md
# Stochastic Cell Phase Sequencer

This controller runs a stochastic bit cell through a repeating three-step operation. First it clears the cell to its low-resistance state with a strong drive in the reverse direction. Next it excites the cell at a level chosen by a target bit. Finally it reads the cell. The sequencer raises one phase enable at a time and puts out a drive-level select for the analog multiplexer. At the last read cycle it captures the 1-bit comparator decision into a registered spin bit. A one-cycle valid strobe marks each new sample.

The length of each phase is a parameter counted in clock cycles. The defaults are 5, 5 and 10, which give a 20 ns operation at 1 GHz. An enable input starts the sequence. When enable is dropped, the operation in progress runs to its end and the block then rests with every phase enable low. The target bit is taken once per operation, when excite begins. The block is meant to sit beside every cell of a spin array, where an annealing controller supplies the targets and collects the sampled spins.

Top module: `cell_phase_seq`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, ph_reset, ph_excite and ph_read are low, drv_sel is 2'b00, spin_out is 0 and sample_valid is 0.
- R2: With enable low the block stays idle, with all phase enables low and drv_sel 2'b00. A rising clock edge that samples enable high while idle makes ph_reset high from that edge on.
- R3: Operations follow the order reset, excite, read, with at most one phase enable high at a time. While enable stays high, the reset phase of the next operation follows the read phase directly.
- R4: The reset, excite and read phases last RST_CYC, EXC_CYC and RD_CYC cycles, which default to 5, 5 and 10.
- R5: During reset drv_sel is 2'b01, the strong reverse drive. During read and idle it is 2'b00, no drive.
- R6: During excite drv_sel is 2'b11 (high level) when the latched target is 1 and 2'b10 (low level) when it is 0.
- R7: The target is the value of target_bit in the last reset cycle. A change of target_bit during excite or read has no effect on drv_sel until the next operation.
- R8: spin_out takes the value cmp_in had in the last read cycle and changes at no other time. cmp_in has no effect during reset, excite or idle.
- R9: sample_valid is high for exactly one cycle, the cycle after the last read cycle, which is also the first cycle in which the new spin_out is seen.
- R10: If enable is low at the end of read, the block goes idle: all phase enables are low and drv_sel is 2'b00, while spin_out holds the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; sampled at idle and at the end of read |
| target_bit | input | 1 | Wanted cell value; selects the excite level |
| cmp_in | input | 1 | Comparator decision, 1 = high resistance |
| ph_reset | output | 1 | Reset phase enable |
| ph_excite | output | 1 | Excite phase enable |
| ph_read | output | 1 | Read phase enable |
| drv_sel | output | 2 | Drive select: 00 none, 01 reverse, 10 low, 11 high |
| spin_out | output | 1 | Registered spin sample |
| sample_valid | output | 1 | One-cycle strobe with each new sample |

## Verification
The properties assume that enable, target_bit and cmp_in are synchronous to clk and settle before each rising edge. They make no assumption about when these inputs change relative to the phase boundaries. The stimulus changes every input only at falling edges. To exercise R7 and R8, it deliberately toggles target_bit in the middle of excite and holds cmp_in at the opposite value outside read. It also drops enable part way through an operation to show that the operation is finished before the block goes idle.

// File: rtl/cell_phase_seq.sv
module cell_phase_seq #(
  parameter int RST_CYC = 5,
  parameter int EXC_CYC = 5,
  parameter int RD_CYC  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       target_bit,
  input  logic       cmp_in,
  output logic       ph_reset,
  output logic       ph_excite,
  output logic       ph_read,
  output logic [1:0] drv_sel,
  output logic       spin_out,
  output logic       sample_valid
);
  localparam int MAXL = (RST_CYC > EXC_CYC) ? ((RST_CYC > RD_CYC) ? RST_CYC : RD_CYC)
                                            : ((EXC_CYC > RD_CYC) ? EXC_CYC : RD_CYC);
  localparam int CW = $clog2(MAXL + 1);

  typedef enum logic [1:0] {S_IDLE, S_RST, S_EXC, S_RD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          tgt_q, spin_q, vld_q;
  logic          last;

  assign last = (st == S_RST && cnt == CW'(RST_CYC - 1)) ||
                (st == S_EXC && cnt == CW'(EXC_CYC - 1)) ||
                (st == S_RD  && cnt == CW'(RD_CYC  - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      tgt_q  <= 1'b0;
      spin_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      cnt   <= last ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (enable) st <= S_RST;
        end
        S_RST: if (last) begin
          st    <= S_EXC;
          tgt_q <= target_bit;
        end
        S_EXC: if (last) st <= S_RD;
        default: if (last) begin
          spin_q <= cmp_in;
          vld_q  <= 1'b1;
          st     <= enable ? S_RST : S_IDLE;
        end
      endcase
    end
  end

  assign ph_reset     = (st == S_RST);
  assign ph_excite    = (st == S_EXC);
  assign ph_read      = (st == S_RD);
  assign drv_sel      = ph_reset ? 2'b01 : (ph_excite ? {1'b1, tgt_q} : 2'b00);
  assign spin_out     = spin_q;
  assign sample_valid = vld_q;
endmodule

// File: rtl/cell_phase_seq_chk.sv
module cell_phase_seq_chk #(
  parameter int RST_CYC = 5,
  parameter int EXC_CYC = 5,
  parameter int RD_CYC  = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmp_in,
  input logic       ph_reset,
  input logic       ph_excite,
  input logic       ph_read,
  input logic [1:0] drv_sel,
  input logic       spin_out,
  input logic       sample_valid
);
  logic [2:0]  ph, pv;
  logic [15:0] rc;

  assign ph = {ph_reset, ph_excite, ph_read};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= 3'b000;
      rc <= 16'd0;
    end else begin
      pv <= ph;
      rc <= (ph != pv) ? 16'd1 : rc + 16'd1;
    end
  end

  // R3
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ph));
  // R3
  reset_next_chk: assert property (@(posedge clk) disable iff (!rst_n) ph_reset |=> (ph_reset || ph_excite));
  // R3
  excite_next_chk: assert property (@(posedge clk) disable iff (!rst_n) ph_excite |=> (ph_excite || ph_read));
  // R4
  reset_len_chk: assert property (@(posedge clk) disable iff (!rst_n) (pv == 3'b100 && ph != pv) |-> rc == 16'(RST_CYC));
  // R4
  excite_len_chk: assert property (@(posedge clk) disable iff (!rst_n) (pv == 3'b010 && ph != pv) |-> rc == 16'(EXC_CYC));
  // R4
  read_len_chk: assert property (@(posedge clk) disable iff (!rst_n) (pv == 3'b001 && ph != pv) |-> rc == 16'(RD_CYC));
  // R5
  reset_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) ph_reset |-> drv_sel == 2'b01);
  // R7
  excite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (ph_excite && $past(ph_excite)) |-> $stable(drv_sel));
  // R8
  spin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !sample_valid |-> $stable(spin_out));
  // R8
  spin_capture_chk: assert property (@(posedge clk) disable iff (!rst_n) sample_valid |-> spin_out == $past(cmp_in));
  // R9
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n) sample_valid |-> ($past(ph_read) && !ph_read));
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) sample_valid |=> !sample_valid);
endmodule

bind cell_phase_seq cell_phase_seq_chk #(.RST_CYC(RST_CYC), .EXC_CYC(EXC_CYC), .RD_CYC(RD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .ph_reset(ph_reset), .ph_excite(ph_excite),
  .ph_read(ph_read), .drv_sel(drv_sel), .spin_out(spin_out), .sample_valid(sample_valid)
);

// File: tb/sim_cell_phase_seq.sv
`timescale 1ns/1ps
module sim_cell_phase_seq;
  localparam int RST_CYC = 5, EXC_CYC = 5, RD_CYC = 10;
  // {target, cmp, expected drv_sel[1:0], expected spin}
  localparam logic [4:0] VEC [6] = '{5'b11111, 5'b00100, 5'b10110, 5'b01101, 5'b11111, 5'b00100};

  logic clk = 0, rst_n = 0, enable = 0, target_bit = 0, cmp_in = 0;
  logic ph_reset, ph_excite, ph_read, spin_out, sample_valid;
  logic [1:0] drv_sel;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cell_phase_seq #(.RST_CYC(RST_CYC), .EXC_CYC(EXC_CYC), .RD_CYC(RD_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .target_bit(target_bit), .cmp_in(cmp_in),
    .ph_reset(ph_reset), .ph_excite(ph_excite), .ph_read(ph_read), .drv_sel(drv_sel),
    .spin_out(spin_out), .sample_valid(sample_valid));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_chk(input string req);
    chk(req, {ph_reset, ph_excite, ph_read}, 0);
    chk(req, drv_sel, 0);
  endtask

  task automatic run_op(input logic tgt, input logic cmp, input logic [1:0] esel,
                        input logic espin, input bit drop, input logic next_rst);
    int n;
    logic prev;
    prev = spin_out;
    target_bit = tgt;
    cmp_in = ~cmp;
    n = 0;
    while (ph_reset === 1'b1 && n < 40) begin
      chk("R5 reverse drive", drv_sel, 1);
      if (n > 0) chk("R9 single pulse", sample_valid, 0);
      chk("R8 spin held in reset", spin_out, prev);
      n++;
      @(negedge clk);
    end
    chk("R4 reset length", n, RST_CYC);
    chk("R3 excite after reset", ph_excite, 1);
    n = 0;
    while (ph_excite === 1'b1 && n < 40) begin
      chk("R6 excite level", drv_sel, esel);
      chk("R8 spin held in excite", spin_out, prev);
      if (n == 1) begin
        target_bit = ~tgt;
        if (drop) enable = 0;
      end
      n++;
      @(negedge clk);
    end
    chk("R4 excite length", n, EXC_CYC);
    chk("R3 read after excite", ph_read, 1);
    cmp_in = cmp;
    n = 0;
    while (ph_read === 1'b1 && n < 40) begin
      chk("R5 no drive in read", drv_sel, 0);
      chk("R9 no strobe in read", sample_valid, 0);
      chk("R7 R8 spin held in read", spin_out, prev);
      n++;
      @(negedge clk);
    end
    chk("R4 read length", n, RD_CYC);
    chk("R9 strobe after read", sample_valid, 1);
    chk("R8 captured spin", spin_out, espin);
    chk("R3 R10 next phase", ph_reset, next_rst);
    cmp_in = ~cmp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R1 in reset");
    chk("R1 spin", spin_out, 0);
    chk("R1 valid", sample_valid, 0);
    rst_n = 1;
    @(negedge clk);
    idle_chk("R1 after reset");
    chk("R1 valid after reset", sample_valid, 0);
    cmp_in = 1;
    target_bit = 1;
    repeat (4) begin
      @(negedge clk);
      idle_chk("R2 idle");
      chk("R8 cmp ignored idle", spin_out, 0);
    end
    enable = 1;
    @(negedge clk);
    chk("R2 start", ph_reset, 1);
    for (int i = 0; i < 6; i++)
      run_op(VEC[i][4], VEC[i][3], VEC[i][2:1], VEC[i][0], i == 5, (i == 5) ? 1'b0 : 1'b1);
    cmp_in = 1;
    @(negedge clk);
    repeat (5) begin
      idle_chk("R10 idle after stop");
      chk("R10 spin held", spin_out, 0);
      chk("R9 no strobe idle", sample_valid, 0);
      @(negedge clk);
    end
    enable = 1;
    @(negedge clk);
    chk("R2 restart", ph_reset, 1);
    run_op(1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    idle_chk("R10 idle after second stop");
    chk("R10 spin held", spin_out, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule